// File: doc/BRIEF.md
# Interrupt Aggregator with Endpoint Suspend Status

This block gathers up to 32 event sources into one level interrupt line toward a host processor. Each source owns one bit in a sticky status register, one bit in an enable register and one bit in a write-one-to-clear acknowledge register. The line is high whenever any status bit is set and its enable bit is also set. Software reads the status, services what it finds, and writes the serviced bits back to the acknowledge register. The host detects a new request on the rising edge of the line.

One top-level bit, position 14, summarises a second level of per-endpoint suspend requests. That level has its own endpoint status, endpoint enable and endpoint acknowledge registers. Bit 14 stays asserted for as long as any endpoint status bit is set. Software therefore clears the endpoint level first and then acknowledges bit 14. Two sources, bits 2 and 3, carry the event and response signals of an embedded mailbox. At this level they behave like any other source.

The block also tracks which endpoints hold an open aggregation frame. A force-close register lets software shut those frames down. Each force-close sends a one-cycle close pulse to the aggregation engine. When the endpoint's suspend enable is set, it also raises that endpoint's suspend bit, so a stalled client receives a wake-up.

Top module: `irqhub_ctrl`

## Requirements
- R1: After reset all registers read zero, irq_o is low and force_close_o is zero.
- R2: A pulse on src_pulse[b] for any b other than 14 sets status bit b (word 0) at the sampling edge. The bit stays set until it is acknowledged, even while its enable bit is clear. Bits 2 and 3 (mailbox event and response) follow the same rule.
- R3: Writing a mask to the acknowledge register (word 2) clears only the status bits that are 1 in the mask. If a set and an acknowledge hit the same bit in the same cycle, the bit stays set.
- R4: irq_o is a register. It is high one cycle after the AND of status and enable is nonzero, and low one cycle after that AND is zero.
- R5: The enable register (word 1) is read/write. A source whose enable bit is clear never drives irq_o.
- R6: Endpoint status (word 3) bit e is set by ep_suspend[e] only when endpoint-enable (word 4) bit e is set. Writing zero to word 4 disables all endpoints. Writing a mask to the endpoint acknowledge register (word 5) clears those bits, and a set in the same cycle wins.
- R7: Status bit 14 is set at the edge after endpoint status becomes nonzero. Acknowledging bit 14 has no effect while endpoint status is nonzero. src_pulse[14] is ignored.
- R8: The aggregation-active register (word 6) bit e is set by agg_open[e] and cleared by agg_done[e]. When a set and a clear arrive in the same cycle, the set wins.
- R9: Writing a mask to the force-close register (word 7) affects each endpoint that is active in the mask. For such an endpoint, its active bit clears and force_close_o[e] pulses for one cycle, both after the same edge. At that edge its endpoint status bit is also set if its endpoint-enable bit is set. Endpoints that are not active are unaffected.
- R10: Words 2, 5 and 7 read zero, and words 8 to 15 read zero. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_pulse | input | NUM_SRC | One-cycle event pulses, one per source |
| ep_suspend | input | NUM_EP | One-cycle suspend requests, one per endpoint |
| agg_open | input | NUM_EP | Aggregation frame opened on an endpoint |
| agg_done | input | NUM_EP | Aggregation frame closed normally on an endpoint |
| force_close_o | output | NUM_EP | One-cycle close command toward the aggregation engine |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
The following registers take a register write, an event pulse or an aggregation pulse at the first rising edge: status, enable, endpoint status, endpoint enable, aggregation-active and force_close_o. Their new value is visible after that edge. Status bit 14 lags endpoint status by one more edge. irq_o lags the status-and-enable pair by one edge, so an event that is already enabled reaches the line two edges after its pulse. The bench drives every input just after a rising edge. It steps a behavioural model at each rising edge and compares irq_o, force_close_o and the read data at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;

  localparam int BUS_DW = 32;
  localparam int REG_AW = 4;

  // Register word addresses
  typedef enum logic [REG_AW-1:0] {
    RS_STATUS    = 4'd0,
    RS_ENABLE    = 4'd1,
    RS_ACK       = 4'd2,
    RS_EP_STATUS = 4'd3,
    RS_EP_ENABLE = 4'd4,
    RS_EP_ACK    = 4'd5,
    RS_AGG_ACT   = 4'd6,
    RS_FORCE     = 4'd7
  } reg_sel_e;

endpackage

// File: rtl/irqhub_sticky.sv
// Bank of sticky bits: a set pulse latches a bit, a clear mask drops it,
// and a set in the same cycle takes priority over the clear.
module irqhub_sticky #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  function automatic logic bit_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  logic [W-1:0] q_r;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r[i] <= 1'b0;
      else        q_r[i] <= bit_next(q_r[i], set_i[i], clr_i[i]);
    end
  end

  assign q_o = q_r;

  // R2: a bit that saw a set pulse is high after the edge
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_i) & ~q_r) == '0));

  // R3: a bit may only fall where a clear was requested
  p_fall_needs_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(q_r) & ~q_r) & ~$past(clr_i)) == '0));

endmodule

// File: rtl/irqhub_regif.sv
// Register decode: holds the two enable registers, turns writes into
// one-cycle masks, and multiplexes read data.
module irqhub_regif
  import irqhub_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_EP  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [BUS_DW-1:0]  bus_wdata,
  output logic [BUS_DW-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] status_q,
  input  logic [NUM_EP-1:0]  ep_status_q,
  input  logic [NUM_EP-1:0]  agg_q,
  output logic [NUM_SRC-1:0] enable_q,
  output logic [NUM_EP-1:0]  ep_enable_q,
  output logic [NUM_SRC-1:0] ack_mask,
  output logic [NUM_EP-1:0]  ep_ack_mask,
  output logic [NUM_EP-1:0]  force_mask
);

  function automatic logic [BUS_DW-1:0] widen_src(input logic [NUM_SRC-1:0] v);
    logic [BUS_DW-1:0] r;
    r = '0;
    r[NUM_SRC-1:0] = v;
    return r;
  endfunction

  function automatic logic [BUS_DW-1:0] widen_ep(input logic [NUM_EP-1:0] v);
    logic [BUS_DW-1:0] r;
    r = '0;
    r[NUM_EP-1:0] = v;
    return r;
  endfunction

  reg_sel_e sel;
  logic     wr_enable, wr_ep_enable, wr_ack, wr_ep_ack, wr_force;

  assign sel          = reg_sel_e'(bus_addr);
  assign wr_enable    = bus_we && (sel == RS_ENABLE);
  assign wr_ep_enable = bus_we && (sel == RS_EP_ENABLE);
  assign wr_ack       = bus_we && (sel == RS_ACK);
  assign wr_ep_ack    = bus_we && (sel == RS_EP_ACK);
  assign wr_force     = bus_we && (sel == RS_FORCE);

  assign ack_mask    = wr_ack    ? bus_wdata[NUM_SRC-1:0] : '0;
  assign ep_ack_mask = wr_ep_ack ? bus_wdata[NUM_EP-1:0]  : '0;
  assign force_mask  = wr_force  ? bus_wdata[NUM_EP-1:0]  : '0;

  logic [NUM_SRC-1:0] enable_r;
  logic [NUM_EP-1:0]  ep_enable_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_r    <= '0;
      ep_enable_r <= '0;
    end else begin
      if (wr_enable)    enable_r    <= bus_wdata[NUM_SRC-1:0];
      if (wr_ep_enable) ep_enable_r <= bus_wdata[NUM_EP-1:0];
    end
  end

  assign enable_q    = enable_r;
  assign ep_enable_q = ep_enable_r;

  always_comb begin
    bus_rdata = '0;
    case (sel)
      RS_STATUS:    bus_rdata = widen_src(status_q);
      RS_ENABLE:    bus_rdata = widen_src(enable_r);
      RS_EP_STATUS: bus_rdata = widen_ep(ep_status_q);
      RS_EP_ENABLE: bus_rdata = widen_ep(ep_enable_r);
      RS_AGG_ACT:   bus_rdata = widen_ep(agg_q);
      default:      bus_rdata = '0;
    endcase
  end

  // R5: an enable write is reflected by the register at the next edge
  p_enable_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> (enable_r == $past(bus_wdata[NUM_SRC-1:0])));

  // R6: writing zero to the endpoint enable turns every endpoint off
  p_ep_enable_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ep_enable && (bus_wdata[NUM_EP-1:0] == '0)) |=> (ep_enable_r == '0));

endmodule

// File: rtl/irqhub_agg.sv
// Aggregation-active tracking and the force-close path.
module irqhub_agg #(
  parameter int NUM_EP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] agg_open,
  input  logic [NUM_EP-1:0] agg_done,
  input  logic [NUM_EP-1:0] force_mask,
  output logic [NUM_EP-1:0] agg_q,
  output logic [NUM_EP-1:0] force_hit,
  output logic [NUM_EP-1:0] force_pulse_o
);

  function automatic logic [NUM_EP-1:0] closing(input logic [NUM_EP-1:0] req,
                                                input logic [NUM_EP-1:0] act);
    return req & act;
  endfunction

  logic [NUM_EP-1:0] drop_vec;
  logic [NUM_EP-1:0] pulse_r;

  assign force_hit = closing(force_mask, agg_q);
  assign drop_vec  = agg_done | force_mask;

  irqhub_sticky #(.W(NUM_EP)) u_active (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (agg_open),
    .clr_i (drop_vec),
    .q_o   (agg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_r <= '0;
    else        pulse_r <= force_hit;
  end

  assign force_pulse_o = pulse_r;

  // R9: a close pulse only goes to endpoints that were active
  p_fc_only_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pulse_r & ~$past(agg_q)) == '0));

  // R9: a closed endpoint is no longer active unless it reopened
  p_fc_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pulse_r & agg_q & ~$past(agg_open)) == '0));

endmodule

// File: rtl/irqhub_ctrl.sv
// Interrupt aggregator top: top-level status, endpoint suspend status,
// aggregation tracking and the registered interrupt line.
module irqhub_ctrl
  import irqhub_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_EP   = 32,
  parameter int SUSP_BIT = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [BUS_DW-1:0]  bus_wdata,
  output logic [BUS_DW-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic [NUM_EP-1:0]  ep_suspend,
  input  logic [NUM_EP-1:0]  agg_open,
  input  logic [NUM_EP-1:0]  agg_done,
  output logic [NUM_EP-1:0]  force_close_o,
  output logic               irq_o
);

  localparam logic [NUM_SRC-1:0] SUSP_ONEHOT = NUM_SRC'(1) << SUSP_BIT;

  function automatic logic any_pending(input logic [NUM_SRC-1:0] st,
                                       input logic [NUM_SRC-1:0] en);
    return |(st & en);
  endfunction

  function automatic logic [NUM_SRC-1:0] top_sets(input logic [NUM_SRC-1:0] pulses,
                                                  input logic summary);
    return (pulses & ~SUSP_ONEHOT) | (summary ? SUSP_ONEHOT : '0);
  endfunction

  logic [NUM_SRC-1:0] status_q, enable_q, ack_mask, status_set;
  logic [NUM_EP-1:0]  ep_status_q, ep_enable_q, ep_ack_mask, ep_set;
  logic [NUM_EP-1:0]  force_mask, force_hit, agg_q;
  logic               ep_nonzero;
  logic               pend_now;
  logic               irq_r;

  irqhub_regif #(.NUM_SRC(NUM_SRC), .NUM_EP(NUM_EP)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .status_q    (status_q),
    .ep_status_q (ep_status_q),
    .agg_q       (agg_q),
    .enable_q    (enable_q),
    .ep_enable_q (ep_enable_q),
    .ack_mask    (ack_mask),
    .ep_ack_mask (ep_ack_mask),
    .force_mask  (force_mask)
  );

  irqhub_agg #(.NUM_EP(NUM_EP)) u_agg (
    .clk           (clk),
    .rst_n         (rst_n),
    .agg_open      (agg_open),
    .agg_done      (agg_done),
    .force_mask    (force_mask),
    .agg_q         (agg_q),
    .force_hit     (force_hit),
    .force_pulse_o (force_close_o)
  );

  // Endpoint suspend level: requests and force-close wakeups, gated per endpoint
  assign ep_set     = (ep_suspend | force_hit) & ep_enable_q;
  assign ep_nonzero = |ep_status_q;

  irqhub_sticky #(.W(NUM_EP)) u_ep_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ep_set),
    .clr_i (ep_ack_mask),
    .q_o   (ep_status_q)
  );

  // Top level: the suspend bit mirrors the endpoint level, not its pulse input
  assign status_set = top_sets(src_pulse, ep_nonzero);

  irqhub_sticky #(.W(NUM_SRC)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (status_set),
    .clr_i (ack_mask),
    .q_o   (status_q)
  );

  assign pend_now = any_pending(status_q, enable_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_r <= 1'b0;
    else        irq_r <= pend_now;
  end

  assign irq_o = irq_r;

  // R4: the line only rises for an enabled pending source
  p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_r |-> ($past(|(status_q & enable_q))));

  // R7: a nonzero endpoint level holds the summary bit on the next edge
  p_summary_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ep_nonzero |=> status_q[SUSP_BIT]);

  // R6: new endpoint bits appear only where the endpoint was enabled
  p_ep_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ep_status_q & ~$past(ep_status_q) & ~$past(ep_enable_q)) == '0));

  // R7: the summary bit never rises without endpoint status behind it
  p_summary_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[SUSP_BIT]) |-> $past(ep_nonzero));

endmodule

// File: tb/sim_irqhub_ctrl.sv
`timescale 1ns/1ps
module sim_irqhub_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_pulse = '0;
  logic [31:0] ep_suspend = '0;
  logic [31:0] agg_open = '0;
  logic [31:0] agg_done = '0;
  logic [31:0] force_close_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  irqhub_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pulse(src_pulse),
    .ep_suspend(ep_suspend), .agg_open(agg_open), .agg_done(agg_done),
    .force_close_o(force_close_o), .irq_o(irq_o)
  );

  // Behavioural reference state
  logic [31:0] m_status, m_enable, m_ep, m_ep_en, m_agg, m_fc;
  logic        m_irq;

  always @(posedge clk) begin
    logic [31:0] ack, epack, fc, sets, n_status, n_ep, n_agg;
    if (!rst_n) begin
      m_status = 0; m_enable = 0; m_ep = 0; m_ep_en = 0;
      m_agg = 0; m_fc = 0; m_irq = 0;
    end else begin
      ack   = (bus_we && bus_addr == 4'd2) ? bus_wdata : 32'h0;
      epack = (bus_we && bus_addr == 4'd5) ? bus_wdata : 32'h0;
      fc    = (bus_we && bus_addr == 4'd7) ? bus_wdata : 32'h0;
      sets = src_pulse;
      sets[14] = (m_ep != 0);
      n_status = sets | (m_status & ~ack);
      n_ep  = ((ep_suspend | (fc & m_agg)) & m_ep_en) | (m_ep & ~epack);
      n_agg = agg_open | (m_agg & ~(agg_done | fc));
      m_irq = (m_status & m_enable) != 0;
      m_fc  = fc & m_agg;
      if (bus_we && bus_addr == 4'd1) m_enable = bus_wdata;
      if (bus_we && bus_addr == 4'd4) m_ep_en = bus_wdata;
      m_status = n_status; m_ep = n_ep; m_agg = n_agg;
      started = 1;
    end
  end

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return m_status;
      4'd1: return m_enable;
      4'd3: return m_ep;
      4'd4: return m_ep_en;
      4'd6: return m_agg;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(input logic [3:0] a);
    case (a)
      4'd0: return "R2";
      4'd1: return "R5";
      4'd3: return "R6";
      4'd4: return "R6";
      4'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      check({31'b0, irq_o}, 32'h0, "R1 irq in reset");
      check(force_close_o, 32'h0, "R1 force_close in reset");
    end else if (started && !finished) begin
      check({31'b0, irq_o}, {31'b0, m_irq}, "R4 irq line");
      check(force_close_o, m_fc, "R9 close pulse");
      check(bus_rdata, model_read(bus_addr), read_tag(bus_addr));
    end
  end

  task automatic drive(input logic [31:0] src, input logic [31:0] ep,
                       input logic [31:0] op, input logic [31:0] dn,
                       input logic we, input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    src_pulse = src; ep_suspend = ep; agg_open = op; agg_done = dn;
    bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 1'b0, bus_addr, 0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    drive(0, 0, 0, 0, 1'b1, a, d);
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    drive(0, 0, 0, 0, 1'b0, a, 0);
    @(negedge clk);
    check(bus_rdata, exp, tag);
  endtask

  task automatic expect_fc(input logic [31:0] exp, input string tag);
    idle();
    @(negedge clk);
    check(force_close_o, exp, tag);
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    idle();
    @(negedge clk);
    check({31'b0, irq_o}, {31'b0, exp}, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    expect_rd(4'd0, 32'h0, "R1 status");
    expect_rd(4'd1, 32'h0, "R1 enable");
    expect_rd(4'd6, 32'h0, "R1 agg");

    // sticky mailbox bits while disabled
    drive(32'h0000_000C, 0, 0, 0, 1'b0, 4'd0, 0);
    expect_rd(4'd0, 32'h0000_000C, "R2 mailbox bits");
    expect_irq(1'b0, "R5 disabled source");
    wr(4'd1, 32'h8);
    expect_rd(4'd1, 32'h8, "R5 enable readback");
    expect_irq(1'b1, "R4 irq rises");
    wr(4'd1, 32'h0);
    expect_rd(4'd0, 32'h0000_000C, "R2 held while disabled");
    expect_irq(1'b0, "R4 irq falls");
    wr(4'd1, 32'h8);

    // acknowledge behaviour
    drive(32'h8, 0, 0, 0, 1'b1, 4'd2, 32'h8);
    expect_rd(4'd0, 32'h0000_000C, "R3 set beats ack");
    wr(4'd2, 32'h4);
    expect_rd(4'd0, 32'h0000_0008, "R3 only masked bit");
    wr(4'd2, 32'h8);
    expect_rd(4'd0, 32'h0, "R3 cleared");
    expect_rd(4'd2, 32'h0, "R10 ack reads zero");
    expect_irq(1'b0, "R4 irq low after ack");

    // endpoint suspend level
    wr(4'd4, 32'h0000_00F0);
    drive(0, 32'h11, 0, 0, 1'b0, 4'd0, 0);
    expect_rd(4'd3, 32'h10, "R6 gated endpoint set");
    expect_rd(4'd0, 32'h4000, "R7 summary set");
    wr(4'd2, 32'h4000);
    expect_rd(4'd0, 32'h4000, "R7 ack ignored while nonzero");
    drive(0, 32'h20, 0, 0, 1'b1, 4'd5, 32'h10);
    expect_rd(4'd3, 32'h20, "R6 ep ack and set");
    wr(4'd5, 32'h20);
    expect_rd(4'd3, 32'h0, "R6 ep ack");
    wr(4'd2, 32'h4000);
    expect_rd(4'd0, 32'h0, "R7 summary acked");
    drive(32'h4000, 0, 0, 0, 1'b0, 4'd0, 0);
    expect_rd(4'd0, 32'h0, "R7 src 14 ignored");
    wr(4'd4, 32'h0);
    drive(0, 32'hFF, 0, 0, 1'b0, 4'd0, 0);
    expect_rd(4'd3, 32'h0, "R6 all disabled");

    // aggregation tracking and force-close
    drive(0, 0, 32'h210, 0, 1'b0, 4'd0, 0);
    expect_rd(4'd6, 32'h210, "R8 open");
    drive(0, 0, 0, 32'h200, 1'b0, 4'd0, 0);
    expect_rd(4'd6, 32'h10, "R8 done");
    wr(4'd4, 32'h10);
    wr(4'd7, 32'h30);
    expect_fc(32'h10, "R9 pulse on active only");
    expect_rd(4'd6, 32'h0, "R9 closed");
    expect_rd(4'd3, 32'h10, "R9 wake raised");
    drive(0, 0, 32'h200, 0, 1'b0, 4'd0, 0);
    wr(4'd7, 32'h200);
    expect_fc(32'h200, "R9 pulse disabled ep");
    expect_rd(4'd3, 32'h10, "R9 no wake when disabled");
    drive(0, 0, 32'h80, 0, 1'b0, 4'd0, 0);
    drive(0, 0, 32'h80, 0, 1'b1, 4'd7, 32'h80);
    expect_fc(32'h80, "R9 pulse with reopen");
    expect_rd(4'd6, 32'h80, "R8 open wins");
    expect_rd(4'd7, 32'h0, "R10 force reads zero");
    expect_rd(4'd5, 32'h0, "R10 ep ack reads zero");
    expect_rd(4'd9, 32'h0, "R10 unmapped");

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 9));
      drive($urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
            $urandom & $urandom, $urandom & $urandom,
            ($urandom_range(0, 2) == 0), a, $urandom);
    end
    idle();
    idle();
    @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule